// File: doc/BRIEF.md
# PCI Data Parity Checker and Reporter

This block sits on one bus side of a PCI-to-PCI bridge. It checks the parity of every data phase and reports errors. On each completed data phase it takes the 32-bit address/data lines and the four active-low byte enables. It takes the parity line one clock later and checks that the 37 bits hold an even number of ones. The check runs only when the bridge receives the data on this side.

A mismatch produces three results:
- A one-clock low pulse on the bus parity-error line, if the parity-error-response enable is set.
- A sticky "parity error detected" flag, which is set whatever the enable says.
- A sticky "master data parity error" flag, which is set only when the enable is on and the bridge was the master reading data.

When the bridge is the master writing data, a parity-error signal from the target also sets the master flag, provided the enable is on. When the bridge is a target returning read data, an error signal from the initiator is ignored.

Integration logic supplies the bus signals, a phase-completed strobe, two role bits and the enable. It drives the parity-error pin from the output value and output enable. Software clears the status flags with write-one-to-clear strobes.

Top module: `pci_par_chk`

## Requirements
- R1: Parity is even. A data phase completed at clock edge T is in error when the data lines (sampled at T), the four byte-enable lines (sampled at T) and the parity line (sampled at edge T+1) together hold an odd number of ones.
- R2: A checked phase in error, with the enable set, drives `perr_n_o` low with `perr_oe_o` high for exactly the clock period after edge T+2.
- R3: With the enable clear at edge T+2, a phase in error does not drive `perr_n_o` low.
- R4: A checked phase in error sets `dpe_o` at edge T+2, whatever the state of the enable.
- R5: `mdpe_o` is set by an own parity error only when the enable is set and the role is master receiving (`receiver_i`=1, `master_i`=1). A target receiving an error leaves it clear.
- R6: In the master-sending role (`receiver_i`=0, `master_i`=1), `perr_n_i` low at edge T+3 with the enable set sets `mdpe_o` at that edge.
- R7: In the target-sending role (`receiver_i`=0, `master_i`=0), `perr_n_i` has no effect: no flag is set and no pulse is driven.
- R8: After its last low cycle, `perr_n_o` is driven high with `perr_oe_o` set for one clock and then released (`perr_oe_o`=0). Errors on back-to-back phases keep it low without a gap.
- R9: `dpe_o` and `mdpe_o` are sticky. A one on `clr_dpe_i` or `clr_mdpe_i` at an edge clears the matching flag, but a set at that same edge wins.
- R10: Phases with `receiver_i`=0 are never parity-checked, so bad parity in them sets nothing.
- R11: While `rst` is high and after it falls, the outputs are `perr_n_o`=1, `perr_oe_o`=0, `dpe_o`=0 and `mdpe_o`=0 until a new event occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| ad_i | input | 32 | Address/data lines |
| cbe_n_i | input | 4 | Active-low command/byte-enable lines |
| par_i | input | 1 | Parity line, valid one clock after its data |
| phase_done_i | input | 1 | A data phase completes at this edge |
| receiver_i | input | 1 | Bridge receives the data of this phase |
| master_i | input | 1 | Bridge is the bus master of this phase |
| resp_en_i | input | 1 | Parity-error-response enable |
| perr_n_i | input | 1 | Parity-error line as seen on the bus |
| clr_dpe_i | input | 1 | Write-one-to-clear strobe for `dpe_o` |
| clr_mdpe_i | input | 1 | Write-one-to-clear strobe for `mdpe_o` |
| perr_n_o | output | 1 | Parity-error drive value |
| perr_oe_o | output | 1 | Parity-error output enable |
| dpe_o | output | 1 | Sticky parity-error-detected flag |
| mdpe_o | output | 1 | Sticky master-data-parity-error flag |

## Verification
Each result has a fixed due time after the edge T at which the phase completes:
- The low pulse and `dpe_o` appear after edge T+2, together with an own-error `mdpe_o`.
- A peer-reported `mdpe_o` appears after edge T+3.
- The high release cycle follows at T+3, and the output enable falls after T+4.

The bench steps one edge at a time and samples on falling edges. Every check sits at the half-cycle right after the edge that is due to produce the result. The sweep covers all four roles, both enable states, good and bad parity, and peer error present or absent. Dedicated sequences cover back-to-back errors and a clear colliding with a set.

// File: rtl/pci_par_pkg.sv
package pci_par_pkg;

    // role of the bridge on this bus for one data phase: {receiver, master}
    typedef enum logic [1:0] {
        ROLE_TGT_SEND = 2'b00,
        ROLE_MST_SEND = 2'b01,
        ROLE_TGT_RECV = 2'b10,
        ROLE_MST_RECV = 2'b11
    } role_e;

    typedef struct packed {
        logic  valid;
        role_e role;
        logic  sum;     // XOR of data and byte enables
    } phase_t;

    typedef struct packed {
        logic own_err;     // parity mismatch on a checked phase
        logic own_mst;     // that phase was a master read
        logic peer_watch;  // phase sent as master, watch peer error line
    } verdict_t;

    localparam int STICKY_N = 2;
    localparam int IDX_DPE  = 0;
    localparam int IDX_MDPE = 1;

    function automatic logic role_checks(input role_e r);
        return (r == ROLE_TGT_RECV) || (r == ROLE_MST_RECV);
    endfunction

    function automatic logic role_watches_peer(input role_e r);
        return r == ROLE_MST_SEND;
    endfunction

endpackage

// File: rtl/pci_par_capture.sv
module pci_par_capture
    import pci_par_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int BE_W   = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] ad_i,
    input  logic [BE_W-1:0]   cbe_n_i,
    input  logic              par_i,
    input  logic              phase_done_i,
    input  logic              receiver_i,
    input  logic              master_i,
    output verdict_t          verdict_o
);

    localparam int SUM_W = DATA_W + BE_W;

    phase_t            s1_q;
    verdict_t          v_q;
    logic [SUM_W-1:0]  bits;

    assign bits = {ad_i, cbe_n_i};

    // edge T: fold data phase into one bit and remember the role
    always_ff @(posedge clk) begin
        if (rst) begin
            s1_q <= '0;
        end else begin
            s1_q.valid <= phase_done_i;
            s1_q.role  <= role_e'({receiver_i, master_i});
            s1_q.sum   <= ^bits;
        end
    end

    // edge T+1: parity line arrives, form the verdict
    always_ff @(posedge clk) begin
        if (rst) begin
            v_q <= '0;
        end else begin
            v_q.own_err    <= s1_q.valid && role_checks(s1_q.role) && (s1_q.sum ^ par_i);
            v_q.own_mst    <= s1_q.role == ROLE_MST_RECV;
            v_q.peer_watch <= s1_q.valid && role_watches_peer(s1_q.role);
        end
    end

    assign verdict_o = v_q;

endmodule

// File: rtl/pci_perr_drv.sv
module pci_perr_drv (
    input  logic clk,
    input  logic rst,
    input  logic fire_i,
    output logic perr_n_o,
    output logic perr_oe_o
);

    logic low_q;
    logic tail_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            low_q  <= 1'b0;
            tail_q <= 1'b0;
        end else begin
            low_q  <= fire_i;
            tail_q <= low_q;
        end
    end

    assign perr_n_o  = !low_q;
    assign perr_oe_o = low_q || tail_q;

    // R8: a low pulse ends with a driven-high cycle
    assert_high_before_release_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(perr_n_o) |-> perr_oe_o);

    // R8: the driver lets go only after driving high
    assert_release_from_high_R8: assert property (@(posedge clk) disable iff (rst)
        $fell(perr_oe_o) |-> $past(perr_n_o));

endmodule

// File: rtl/pci_par_sticky.sv
module pci_par_sticky #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] q_o
);

    for (genvar i = 0; i < N; i++) begin : g_bit
        logic q;
        always_ff @(posedge clk) begin
            if (rst)           q <= 1'b0;
            else if (set_i[i]) q <= 1'b1;
            else if (clr_i[i]) q <= 1'b0;
        end
        assign q_o[i] = q;

        assert_sticky_hold_R9: assert property (@(posedge clk) disable iff (rst)
            (q_o[i] && !clr_i[i]) |=> q_o[i]);

        assert_set_wins_R9: assert property (@(posedge clk) disable iff (rst)
            set_i[i] |=> q_o[i]);
    end

endmodule

// File: rtl/pci_par_chk.sv
module pci_par_chk
    import pci_par_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int BE_W   = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] ad_i,
    input  logic [BE_W-1:0]   cbe_n_i,
    input  logic              par_i,
    input  logic              phase_done_i,
    input  logic              receiver_i,
    input  logic              master_i,
    input  logic              resp_en_i,
    input  logic              perr_n_i,
    input  logic              clr_dpe_i,
    input  logic              clr_mdpe_i,
    output logic              perr_n_o,
    output logic              perr_oe_o,
    output logic              dpe_o,
    output logic              mdpe_o
);

    verdict_t              verdict;
    logic                  watch_q;
    logic                  peer_hit;
    logic [STICKY_N-1:0]   st_set;
    logic [STICKY_N-1:0]   st_clr;
    logic [STICKY_N-1:0]   st_q;

    pci_par_capture #(.DATA_W(DATA_W), .BE_W(BE_W)) u_cap (
        .clk          (clk),
        .rst          (rst),
        .ad_i         (ad_i),
        .cbe_n_i      (cbe_n_i),
        .par_i        (par_i),
        .phase_done_i (phase_done_i),
        .receiver_i   (receiver_i),
        .master_i     (master_i),
        .verdict_o    (verdict)
    );

    // edge T+2: open the window in which a peer error is sampled (edge T+3)
    always_ff @(posedge clk) begin
        if (rst) watch_q <= 1'b0;
        else     watch_q <= verdict.peer_watch;
    end

    assign peer_hit = watch_q && !perr_n_i;

    pci_perr_drv u_drv (
        .clk       (clk),
        .rst       (rst),
        .fire_i    (verdict.own_err && resp_en_i),
        .perr_n_o  (perr_n_o),
        .perr_oe_o (perr_oe_o)
    );

    always_comb begin
        st_set           = '0;
        st_set[IDX_DPE]  = verdict.own_err;
        st_set[IDX_MDPE] = resp_en_i && ((verdict.own_err && verdict.own_mst) || peer_hit);
        st_clr           = '0;
        st_clr[IDX_DPE]  = clr_dpe_i;
        st_clr[IDX_MDPE] = clr_mdpe_i;
    end

    pci_par_sticky #(.N(STICKY_N)) u_st (
        .clk   (clk),
        .rst   (rst),
        .set_i (st_set),
        .clr_i (st_clr),
        .q_o   (st_q)
    );

    assign dpe_o  = st_q[IDX_DPE];
    assign mdpe_o = st_q[IDX_MDPE];

    // R3: the error pulse only follows an enabled decision edge
    assert_perr_gated_R3: assert property (@(posedge clk) disable iff (rst)
        !perr_n_o |-> $past(resp_en_i));

    // R4: every pulse is accompanied by the detected flag
    assert_perr_marks_dpe_R4: assert property (@(posedge clk) disable iff (rst)
        !perr_n_o |-> dpe_o);

endmodule

// File: tb/pci_par_chk_tb.sv
`timescale 1ns/1ps
module pci_par_chk_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] ad = '0;
    logic [3:0]  cbe_n = '0;
    logic        par = 1'b0;
    logic        pd = 1'b0;
    logic        recv = 1'b0;
    logic        mst = 1'b0;
    logic        en = 1'b0;
    logic        perr_in_n = 1'b1;
    logic        clr_dpe = 1'b0;
    logic        clr_mdpe = 1'b0;
    logic        perr_n, perr_oe, dpe, mdpe;

    int vectors = 0;
    int fails = 0;

    always #10 clk = ~clk;

    pci_par_chk u_dut (
        .clk(clk), .rst(rst), .ad_i(ad), .cbe_n_i(cbe_n), .par_i(par),
        .phase_done_i(pd), .receiver_i(recv), .master_i(mst), .resp_en_i(en),
        .perr_n_i(perr_in_n), .clr_dpe_i(clr_dpe), .clr_mdpe_i(clr_mdpe),
        .perr_n_o(perr_n), .perr_oe_o(perr_oe), .dpe_o(dpe), .mdpe_o(mdpe)
    );

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    function automatic logic even_bit(input logic [31:0] a, input logic [3:0] b);
        int ones = 0;
        for (int i = 0; i < 32; i++) ones += a[i];
        for (int i = 0; i < 4; i++) ones += b[i];
        return logic'(ones % 2);
    endfunction

    task automatic clear_all();
        clr_dpe = 1'b1; clr_mdpe = 1'b1;
        tick();
        clr_dpe = 1'b0; clr_mdpe = 1'b0;
    endtask

    // one isolated phase with full timeline checks
    task automatic run_phase(input logic [31:0] a, input logic [3:0] b, input logic bad,
                             input logic r, input logic m, input logic e, input logic peer);
        logic err, exp_perr, own_m, fin_m;
        err      = bad && r;
        exp_perr = err && e;
        own_m    = err && e && r && m;
        fin_m    = own_m || (e && peer && !r && m);
        recv = r; mst = m; en = e;
        ad = a; cbe_n = b; pd = 1'b1;
        tick();                                  // edge T
        pd = 1'b0; par = even_bit(a, b) ^ bad;   // R1: parity one clock later
        ad = ~a;
        tick();                                  // edge T+1
        tick();                                  // edge T+2
        chk("R2", "perr low", !perr_n, exp_perr);
        chk("R3", "perr oe", perr_oe, exp_perr);
        chk("R4", "dpe", dpe, err);
        chk("R5", "mdpe own", mdpe, own_m);
        perr_in_n = !peer;
        tick();                                  // edge T+3
        perr_in_n = 1'b1;
        chk("R8", "perr high tail", perr_n, 1'b1);
        chk("R8", "oe tail", perr_oe, exp_perr);
        if (!r && !m) chk("R7", "mdpe ignored", mdpe, 1'b0);
        else          chk("R6", "mdpe final", mdpe, fin_m);
        if (!r)       chk("R10", "no dpe when sending", dpe, 1'b0);
        tick();                                  // edge T+4
        chk("R8", "oe released", perr_oe, 1'b0);
        clear_all();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        tick();
        chk("R11", "perr in reset", perr_n, 1'b1);
        chk("R11", "oe in reset", perr_oe, 1'b0);
        tick();
        rst = 1'b0;
        tick();
        chk("R11", "dpe after reset", dpe, 1'b0);
        chk("R11", "mdpe after reset", mdpe, 1'b0);
        chk("R11", "oe after reset", perr_oe, 1'b0);

        // sweep: data pattern x role x enable x bad parity x peer error
        for (int p = 0; p < 4; p++) begin
            for (int role = 0; role < 4; role++) begin
                for (int e = 0; e < 2; e++) begin
                    for (int bad = 0; bad < 2; bad++) begin
                        for (int peer = 0; peer < 2; peer++) begin
                            logic [31:0] a;
                            a = (32'h1 << (p * 9)) ^ (32'h9E37_79B9 * p);
                            run_phase(a, 4'(p * 5 + role), logic'(bad),
                                      logic'(role >> 1), logic'(role & 1),
                                      logic'(e), logic'(peer));
                        end
                    end
                end
            end
        end

        // R8: two back-to-back bad phases, target receiving, enabled
        recv = 1'b1; mst = 1'b0; en = 1'b1;
        ad = 32'hA5A5_0F0F; cbe_n = 4'h3; pd = 1'b1;
        tick();                                           // T
        par = ~even_bit(32'hA5A5_0F0F, 4'h3);
        ad = 32'h0000_0001; cbe_n = 4'h0;
        tick();                                           // T+1
        pd = 1'b0; par = ~even_bit(32'h0000_0001, 4'h0);
        tick();                                           // T+2
        chk("R8", "b2b first low", perr_n, 1'b0);
        tick();                                           // T+3
        chk("R8", "b2b stays low", perr_n, 1'b0);
        chk("R8", "b2b oe", perr_oe, 1'b1);
        tick();                                           // T+4
        chk("R8", "b2b high", perr_n, 1'b1);
        chk("R8", "b2b oe tail", perr_oe, 1'b1);
        tick();
        chk("R8", "b2b release", perr_oe, 1'b0);
        clear_all();

        // R9: clear colliding with a set, then a clear alone
        recv = 1'b1; mst = 1'b1; en = 1'b1;
        ad = 32'h1234_5678; cbe_n = 4'h0; pd = 1'b1;
        tick();                                           // T
        pd = 1'b0; par = ~even_bit(32'h1234_5678, 4'h0);
        tick();                                           // T+1
        clr_dpe = 1'b1; clr_mdpe = 1'b1;
        tick();                                           // T+2: set beats clear
        clr_dpe = 1'b0; clr_mdpe = 1'b0;
        chk("R9", "dpe set wins", dpe, 1'b1);
        chk("R9", "mdpe set wins", mdpe, 1'b1);
        tick(); tick();
        chk("R9", "dpe sticky", dpe, 1'b1);
        chk("R9", "mdpe sticky", mdpe, 1'b1);
        clr_dpe = 1'b1;
        tick();
        clr_dpe = 1'b0;
        chk("R9", "dpe cleared", dpe, 1'b0);
        chk("R9", "mdpe untouched", mdpe, 1'b1);
        clr_mdpe = 1'b1;
        tick();
        clr_mdpe = 1'b0;
        chk("R9", "mdpe cleared", mdpe, 1'b0);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule